// File: doc/BRIEF.md
# Power-On Strap Latch Controller

This block owns a group of six shared pads that carry configuration straps while the part comes out of reset and carry clocks afterwards. Reset starts a timer on the reference clock. While the timer runs, every pad driver is held off, so the external strap resistor sets the pad level. The controller synchronizes those levels into its clock domain. In the cycle the timer expires, it latches them and turns the pad drivers on.

Five of the latched pads form a 5-bit frequency-select code. The sixth chooses the rate of the super-I/O clock: high selects 24 MHz, low selects 48 MHz. A live override input can replace the latched code with a register value at any time. A test-mode input puts every output into three-state.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While reset is asserted, and until the window ends, `pad_oe_o` and `pad_do_o` are all zero and `straps_valid_o` is 0. `sio_24m_o` is 0. With `ovr_en_i` low, `fsel_o` is 0.
- R2: The strap window lasts exactly `WINDOW_CYC` rising clock edges after reset is released. `straps_valid_o` rises on edge number `WINDOW_CYC`, and it falls only on reset.
- R3: At the end of the window, `fsel_o` (with `ovr_en_i` low) takes the synchronized levels of pads 0 to 4, with pad k driving bit k.
- R4: At the end of the window, `sio_24m_o` takes the synchronized level of pad 5: 1 means the 24 MHz rate and 0 means the 48 MHz rate.
- R5: After the latch, changes on `pad_i` have no effect on `fsel_o` or `sio_24m_o` until the next reset.
- R6: With `ovr_en_i` at 1, `fsel_o` equals `ovr_sel_i` in the same cycle, even during the window. With `ovr_en_i` at 0, `fsel_o` is the latched code.
- R7: With `test_mode_i` at 1, `all_hiz_o` is 1 and `pad_oe_o` is all zero. With `test_mode_i` at 0 after the window, `pad_oe_o` is all ones.
- R8: `pad_do_o` follows `clk_src_i` bit for bit where `pad_oe_o` is set, and is 0 everywhere else.
- R9: A pad level that settles at least `SYNC_STAGES` edges before expiry is the value that gets latched, even if the pad changed earlier in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset; starts the strap window |
| pad_i | input | 6 | Pad input levels; bits 0-4 are the frequency straps, bit 5 is the SIO-rate strap |
| clk_src_i | input | 6 | Clock to be driven on each pad once enabled |
| ovr_en_i | input | 1 | 1 selects `ovr_sel_i` in place of the strap code |
| ovr_sel_i | input | 5 | Frequency-select code supplied by a register |
| test_mode_i | input | 1 | 1 three-states all outputs |
| straps_valid_o | output | 1 | Straps are latched and the window is over |
| fsel_o | output | 5 | Frequency-select code in effect |
| sio_24m_o | output | 1 | 1 selects the 24 MHz SIO rate, 0 selects 48 MHz |
| pad_oe_o | output | 6 | Per-pad output enable |
| pad_do_o | output | 6 | Per-pad output data |
| all_hiz_o | output | 1 | Global three-state request |

## Verification
If the window counter is off by one, `straps_valid_o` and `pad_oe_o` change one cycle early or late, and a per-edge check at the end of the window catches this at once. A latch that keeps loading after expiry shows up as soon as the bench moves the pads after the window: `fsel_o` or `sio_24m_o` follows them within the synchronizer depth. A bit swap in the capture path, or a wrong polarity on the SIO strap, shows in the first episode whose random strap pattern is not symmetric. Faults in the override or test-mode gating show in the same cycle as the input change, because both paths are combinational.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;
  localparam int unsigned FS_W    = 5;
  localparam int unsigned PAD_N   = FS_W + 1;
  localparam int unsigned SIO_IDX = FS_W;

  typedef struct packed {
    logic            sio_24m;
    logic [FS_W-1:0] fs;
  } strap_word_t;
endpackage

// File: rtl/strap_por_timer.sv
module strap_por_timer #(
  parameter int unsigned WINDOW_CYC = 28636
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic expire_o,
  output logic done_o
);
  localparam int unsigned CW   = (WINDOW_CYC < 2) ? 1 : $clog2(WINDOW_CYC);
  localparam int unsigned LAST = WINDOW_CYC - 1;

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign expire_o = !done_q && (cnt_q == CW'(LAST));
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (expire_o) done_q <= 1'b1;
      else          cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg_q;
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)     stg_q[s] <= '0;
          else if (s == 0) stg_q[s] <= d_i;
          else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_latch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PAD_N-1:0] pad_i,
  output strap_word_t      word_o
);
  strap_word_t word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= '{sio_24m: pad_i[SIO_IDX], fs: pad_i[FS_W-1:0]};
  end

  assign word_o = word_q;
endmodule

// File: rtl/strap_pad_ctrl.sv
module strap_pad_ctrl #(
  parameter int unsigned PADS = 6
) (
  input  logic            done_i,
  input  logic            test_mode_i,
  input  logic [PADS-1:0] clk_src_i,
  output logic [PADS-1:0] oe_o,
  output logic [PADS-1:0] do_o,
  output logic            hiz_o
);
  logic drive_en;
  assign drive_en = done_i && !test_mode_i;
  assign hiz_o    = test_mode_i;

  generate
    for (genvar p = 0; p < PADS; p++) begin : g_pad
      assign oe_o[p] = drive_en;
      assign do_o[p] = drive_en & clk_src_i[p];
    end
  endgenerate
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
  import strap_latch_pkg::*;
#(
  parameter int unsigned WINDOW_CYC  = 28636,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PAD_N-1:0] pad_i,
  input  logic [PAD_N-1:0] clk_src_i,
  input  logic             ovr_en_i,
  input  logic [FS_W-1:0]  ovr_sel_i,
  input  logic             test_mode_i,
  output logic             straps_valid_o,
  output logic [FS_W-1:0]  fsel_o,
  output logic             sio_24m_o,
  output logic [PAD_N-1:0] pad_oe_o,
  output logic [PAD_N-1:0] pad_do_o,
  output logic             all_hiz_o
);
  logic             expire, done;
  logic [PAD_N-1:0] pad_sync;
  strap_word_t      strap_word;

  strap_por_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
    .clk_i, .rst_ni, .expire_o(expire), .done_o(done)
  );

  strap_sync #(.WIDTH(PAD_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pad_sync)
  );

  strap_capture u_cap (
    .clk_i, .rst_ni, .load_i(expire), .pad_i(pad_sync), .word_o(strap_word)
  );

  strap_pad_ctrl #(.PADS(PAD_N)) u_pads (
    .done_i(done), .test_mode_i, .clk_src_i,
    .oe_o(pad_oe_o), .do_o(pad_do_o), .hiz_o(all_hiz_o)
  );

  assign straps_valid_o = done;
  assign sio_24m_o      = strap_word.sio_24m;
  assign fsel_o         = ovr_en_i ? ovr_sel_i : strap_word.fs;
endmodule

// File: rtl/strap_latch_ctrl_chk.sv
module strap_latch_ctrl_chk
  import strap_latch_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ovr_en_i,
  input logic             test_mode_i,
  input logic             straps_valid_o,
  input logic [FS_W-1:0]  fsel_o,
  input logic             sio_24m_o,
  input logic [PAD_N-1:0] pad_oe_o,
  input logic [PAD_N-1:0] pad_do_o,
  input logic             all_hiz_o
);
  // R1
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !straps_valid_o |-> pad_oe_o == '0);

  // R2
  valid_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(straps_valid_o));

  // R5
  strap_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (straps_valid_o && $past(straps_valid_o) && !ovr_en_i && !$past(ovr_en_i))
      |-> ($stable(fsel_o) && $stable(sio_24m_o)));

  // R7
  hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_hiz_o |-> pad_oe_o == '0);

  // R8
  do_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_do_o & ~pad_oe_o) == '0);

  // R7
  hiz_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i |-> all_hiz_o);
endmodule

bind strap_latch_ctrl strap_latch_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ovr_en_i(ovr_en_i), .test_mode_i(test_mode_i),
  .straps_valid_o(straps_valid_o), .fsel_o(fsel_o), .sio_24m_o(sio_24m_o),
  .pad_oe_o(pad_oe_o), .pad_do_o(pad_do_o), .all_hiz_o(all_hiz_o)
);

// File: tb/strap_latch_ctrl_tb_top.sv
module strap_latch_ctrl_tb_top;
  localparam int unsigned W  = 40;
  localparam int unsigned SS = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] pad_i = '0;
  logic [5:0] clk_src_i = '0;
  logic       ovr_en_i = 1'b0;
  logic [4:0] ovr_sel_i = '0;
  logic       test_mode_i = 1'b0;
  logic       straps_valid_o, sio_24m_o, all_hiz_o;
  logic [4:0] fsel_o;
  logic [5:0] pad_oe_o, pad_do_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  strap_latch_ctrl #(.WINDOW_CYC(W), .SYNC_STAGES(SS)) dut_i (
    .clk_i, .rst_ni, .pad_i, .clk_src_i, .ovr_en_i, .ovr_sel_i, .test_mode_i,
    .straps_valid_o, .fsel_o, .sio_24m_o, .pad_oe_o, .pad_do_o, .all_hiz_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] exp_do(input logic [5:0] src, input bit en);
    return en ? src : 6'h0;
  endfunction

  task automatic settle;
    @(negedge clk_i);
    #1;
  endtask

  task automatic episode(input int e);
    logic [5:0] exp_pads;
    logic [4:0] sel;
    rst_ni = 1'b0;
    ovr_en_i = 1'b0;
    test_mode_i = 1'b0;
    exp_pads = 6'($urandom);
    if (e == 0) exp_pads = 6'h21;
    if (e == 1) exp_pads = 6'h1e;
    pad_i = exp_pads;
    clk_src_i = 6'($urandom);
    repeat (3) settle();
    // R1 reset state
    chk(pad_oe_o == 0 && pad_do_o == 0 && !straps_valid_o, "R1", {pad_oe_o, pad_do_o}, 0);
    chk(fsel_o == 0 && sio_24m_o == 0, "R1", {sio_24m_o, fsel_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 1; i < W; i++) begin
      @(posedge clk_i);
      if (i == W/2 && e % 2 == 1) begin
        #2;
        exp_pads = 6'($urandom);
        pad_i = exp_pads; // R9 mid-window change
      end
      if (i == W/4) begin
        settle();
        sel = 5'($urandom);
        ovr_en_i = 1'b1;
        ovr_sel_i = sel;
        #1;
        // R6 override during window
        chk(fsel_o == sel, "R6", fsel_o, sel);
        ovr_en_i = 1'b0;
      end
    end
    settle();
    // R2 window not yet over after W-1 edges
    chk(!straps_valid_o && pad_oe_o == 0, "R2", straps_valid_o, 0);
    chk(fsel_o == 0, "R1", fsel_o, 0);
    settle();
    chk(straps_valid_o, "R2", straps_valid_o, 1);
    chk(fsel_o == exp_pads[4:0], (e % 2) ? "R9" : "R3", fsel_o, exp_pads[4:0]);
    chk(sio_24m_o == exp_pads[5], "R4", sio_24m_o, exp_pads[5]);
    chk(pad_oe_o == 6'h3f, "R7", pad_oe_o, 6'h3f);
    chk(pad_do_o == exp_do(clk_src_i, 1), "R8", pad_do_o, clk_src_i);
    clk_src_i = 6'($urandom);
    #1;
    chk(pad_do_o == exp_do(clk_src_i, 1), "R8", pad_do_o, clk_src_i);
    // R5 post-latch pad changes ignored
    pad_i = ~exp_pads;
    repeat (SS + 3) settle();
    chk(fsel_o == exp_pads[4:0] && sio_24m_o == exp_pads[5], "R5",
        {sio_24m_o, fsel_o}, exp_pads);
    // R7 test mode
    test_mode_i = 1'b1;
    #1;
    chk(all_hiz_o && pad_oe_o == 0, "R7", {all_hiz_o, pad_oe_o}, 7'h40);
    chk(pad_do_o == exp_do(clk_src_i, 0), "R8", pad_do_o, 0);
    settle();
    test_mode_i = 1'b0;
    #1;
    chk(!all_hiz_o && pad_oe_o == 6'h3f, "R7", {all_hiz_o, pad_oe_o}, 6'h3f);
    // R6 override after latch, combinational
    sel = 5'($urandom);
    ovr_sel_i = sel;
    ovr_en_i = 1'b1;
    #1;
    chk(fsel_o == sel, "R6", fsel_o, sel);
    ovr_sel_i = ~sel;
    #1;
    chk(fsel_o == ~sel, "R6", fsel_o, ~sel);
    ovr_en_i = 1'b0;
    #1;
    chk(fsel_o == exp_pads[4:0], "R6", fsel_o, exp_pads[4:0]);
    settle();
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    for (int e = 0; e < 8; e++) episode(e);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule